// File: doc/BRIEF.md
# Posted-Write Queue with Line-Fill Read Priority

This block sits between a 64-bit system bus and a 128-bit memory port. The bus posts writes into a sixteen-entry queue at one word per clock, so it never waits on memory unless the queue is full. The memory side removes the queued words and writes them as 16-byte accesses. When two consecutive entries are the two halves of one 128-bit line, they go out as a single access. A word without its partner goes out alone, and its byte enables cover only the half it occupies.

A cache-line fill read can arrive behind a queued write-back. While the read is pending, the queue stops draining so that memory serves the read first. One case overrides this. If the pending read targets a 128-bit line that still has a word in the queue, the block raises a hold output, and the read must wait for it. While the hold is raised, draining continues until that line has left the queue. A read can therefore never return stale data from memory.

Top module: `postwr_queue`

## Requirements
- R1: After reset the queue is empty: `wr_full`, `mem_req` and `rd_hold` are all low.
- R2: `wr_full` is high in exactly the cycles in which sixteen entries are queued, and it is driven combinationally. A write presented while `wr_full` is high is not taken. The bus must keep presenting it, and the write is accepted in a later cycle with no loss.
- R3: Entries reach memory in the order they were accepted. `mem_addr` is the oldest entry's word address shifted right by one bit. While the request is not granted and no write arrives, the access on offer does not change.
- R4: If the oldest entry has address bit 0 equal to 0 and the next entry holds the following word address, both leave on one grant. `mem_data[63:0]` carries the even word, `mem_data[127:64]` carries the odd word, and `mem_be` is 16'hFFFF.
- R5: Otherwise the oldest entry leaves alone and the other half of `mem_data` is zero. An even word uses bits [63:0] with `mem_be` 16'h00FF. An odd word uses bits [127:64] with `mem_be` 16'hFF00.
- R6: While `rd_pending` is high and `rd_hold` is low, `mem_req` is low.
- R7: In every cycle in which `rd_pending` is low and the queue is not empty, `mem_req` is high. Draining therefore resumes in the first cycle after a pending read ends.
- R8: `rd_hold` is high exactly when `rd_pending` is high and a queued entry shares the 128-bit line of `rd_addr` (all address bits above bit 0 are equal). While `rd_hold` is high, the queue drains as it does when no read is pending.
- R9: A write and a granted drain in the same cycle both take effect. The fullness seen in the next cycle reflects both changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Bus presents a write |
| wr_addr | input | ADDR_W | 64-bit word address of the write |
| wr_data | input | WORD_W | Write data |
| wr_full | output | 1 | Queue holds DEPTH entries; write is stalled |
| rd_pending | input | 1 | A line-fill read is waiting for memory |
| rd_addr | input | ADDR_W | Word address of the pending read |
| rd_hold | output | 1 | Pending read hits a queued line and must wait |
| mem_req | output | 1 | A memory write is on offer |
| mem_gnt | input | 1 | Memory takes the offered write this cycle |
| mem_addr | output | ADDR_W-1 | 128-bit line address |
| mem_data | output | 2*WORD_W | Line data |
| mem_be | output | WORD_W/4 | Byte enables of the line |

## Verification
The bench builds the block with DEPTH 16, WORD_W 64 and ADDR_W 6. With only 32 line addresses, random reads often land on a queued line, so hold, stall and pairing cases appear in large numbers. Directed phases fill the queue behind a pending read and keep a write stalled at full. They also mix lone even words, lone odd words and pairs, and walk a hold until the matching line drains. A long pseudo-random sweep then mixes writes, grants and reads against an arithmetic model of the queue.

// File: rtl/postwr_queue.sv
module postwr_queue #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 64,
  parameter int DEPTH  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [WORD_W-1:0]     wr_data,
  output logic                  wr_full,
  input  logic                  rd_pending,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic                  rd_hold,
  output logic                  mem_req,
  input  logic                  mem_gnt,
  output logic [ADDR_W-2:0]     mem_addr,
  output logic [2*WORD_W-1:0]   mem_data,
  output logic [WORD_W/4-1:0]   mem_be
);
  localparam int PW = $clog2(DEPTH);
  localparam int BE_W = WORD_W / 4;
  localparam int HB = BE_W / 2;
  localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [WORD_W-1:0] data_q [DEPTH];
  logic [PW-1:0] head, tail, head1;
  logic [PW:0]   count, npop;
  logic [DEPTH-1:0] hit;
  logic push, pop, pair, odd;

  assign head1   = head + 1'b1;
  assign wr_full = count == FULL_CNT;
  assign push    = wr_valid && !wr_full;

  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    logic [PW-1:0] off;
    assign off    = PW'(g) - head;
    assign hit[g] = ({1'b0, off} < count) &&
                    (addr_q[g][ADDR_W-1:1] == rd_addr[ADDR_W-1:1]);
  end

  assign rd_hold = rd_pending && |hit;
  assign mem_req = (count != '0) && (!rd_pending || rd_hold);

  assign odd  = addr_q[head][0];
  assign pair = (count >= (PW+1)'(2)) && !odd &&
                (addr_q[head1] == addr_q[head] + ADDR_W'(1));

  assign mem_addr = addr_q[head][ADDR_W-1:1];
  assign mem_data = pair ? {data_q[head1], data_q[head]} :
                    odd  ? {data_q[head], WORD_W'(0)} :
                           {WORD_W'(0), data_q[head]};
  assign mem_be   = pair ? {BE_W{1'b1}} :
                    odd  ? {{HB{1'b1}}, {HB{1'b0}}} :
                           {{HB{1'b0}}, {HB{1'b1}}};

  assign pop  = mem_req && mem_gnt;
  assign npop = !pop ? '0 : pair ? (PW+1)'(2) : (PW+1)'(1);

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail] <= wr_addr;
      data_q[tail] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= tail + 1'b1;
      head  <= head + npop[PW-1:0];
      count <= count + {{PW{1'b0}}, push} - npop;
    end
  end
endmodule

// File: rtl/postwr_queue_chk.sv
module postwr_queue_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_valid,
  input logic                wr_full,
  input logic                rd_pending,
  input logic                rd_hold,
  input logic                mem_req,
  input logic                mem_gnt,
  input logic [ADDR_W-2:0]   mem_addr,
  input logic [2*WORD_W-1:0] mem_data,
  input logic [WORD_W/4-1:0] mem_be
);
  localparam int BE_W = WORD_W / 4;
  localparam int HB = BE_W / 2;

  AST_BLOCKED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pending && !rd_hold) |-> !mem_req); // R6

  AST_HOLD_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hold |-> (rd_pending && mem_req)); // R8

  AST_BE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be == {BE_W{1'b1}} || mem_be == {{HB{1'b0}}, {HB{1'b1}}} ||
                 mem_be == {{HB{1'b1}}, {HB{1'b0}}})); // R4

  AST_OFFER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !wr_valid) |=>
      (!mem_req || ($stable(mem_addr) && $stable(mem_data) && $stable(mem_be)))); // R3

  AST_FULL_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_full && !(mem_req && mem_gnt)) |=> wr_full); // R2

  AST_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_req && !mem_gnt) && !rd_pending) |-> mem_req); // R7
endmodule

bind postwr_queue postwr_queue_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/test_postwr_queue.sv
module test_postwr_queue;
  localparam int AW = 6;
  localparam int WW = 64;
  localparam int DP = 16;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, rd_pending = 0, mem_gnt = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [WW-1:0] wr_data = '0;
  logic wr_full, rd_hold, mem_req;
  logic [AW-2:0] mem_addr;
  logic [2*WW-1:0] mem_data;
  logic [WW/4-1:0] mem_be;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [AW-1:0] qa [DP+1];
  logic [WW-1:0] qd [DP+1];
  int n = 0;
  bit lastboth = 0;
  int seq = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #4 clk = ~clk;

  postwr_queue #(.ADDR_W(AW), .WORD_W(WW), .DEPTH(DP)) i_postwr_queue (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_full(wr_full), .rd_pending(rd_pending),
    .rd_addr(rd_addr), .rd_hold(rd_hold), .mem_req(mem_req),
    .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic wv, input logic [AW-1:0] wa, input logic rp,
                      input logic [AW-1:0] ra, input logic gnt, output bit acc);
    bit ef, eh, er, ep, mt;
    logic [127:0] ed;
    logic [15:0] eb;
    int np;
    @(negedge clk);
    wr_valid = wv; wr_addr = wa; wr_data = {seq[31:0], 26'h0, wa};
    rd_pending = rp; rd_addr = ra; mem_gnt = gnt;
    #1;
    ef = (n == DP);
    mt = 0;
    for (int i = 0; i < n; i++) if (qa[i][AW-1:1] == ra[AW-1:1]) mt = 1;
    eh = rp && mt;
    er = (n > 0) && (!rp || eh);
    ep = (n >= 2) && !qa[0][0] && (qa[1] == qa[0] + 1'b1);
    chk(wr_full == ef, lastboth ? "R9" : "R2", 128'(wr_full), 128'(ef));
    chk(rd_hold == eh, "R8", 128'(rd_hold), 128'(eh));
    chk(mem_req == er, !rp ? "R7" : eh ? "R8" : "R6", 128'(mem_req), 128'(er));
    if (er) begin
      ed = ep ? {qd[1], qd[0]} : qa[0][0] ? {qd[0], 64'h0} : {64'h0, qd[0]};
      eb = ep ? 16'hFFFF : qa[0][0] ? 16'hFF00 : 16'h00FF;
      chk(mem_addr == qa[0][AW-1:1], "R3", 128'(mem_addr), 128'(qa[0][AW-1:1]));
      chk(mem_data == ed, ep ? "R4" : "R5", mem_data, ed);
      chk(mem_be == eb, ep ? "R4" : "R5", 128'(mem_be), 128'(eb));
    end
    np = (er && gnt) ? (ep ? 2 : 1) : 0;
    for (int k = 0; k < np; k++) begin
      for (int i = 0; i < n - 1; i++) begin qa[i] = qa[i+1]; qd[i] = qd[i+1]; end
      n--;
    end
    acc = wv && !ef;
    if (acc) begin qa[n] = wa; qd[n] = wr_data; n++; seq++; end
    lastboth = acc && (np > 0);
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit acc;
    logic [AW-1:0] lst [10];
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!wr_full && !mem_req && !rd_hold, "R1", {wr_full, mem_req, rd_hold}, 0);
    step(0, 0, 0, 0, 1, acc);

    // fill behind a pending read, then stall at full
    for (int a = 0; a < 16; a++) step(1, AW'(a), 1, 6'd63, 1, acc);
    for (int k = 0; k < 3; k++) begin
      step(1, 6'd16, 1, 6'd63, 1, acc);
      chk(!acc, "R2", 128'(acc), 0);
    end
    step(1, 6'd16, 0, 0, 0, acc);
    begin
      int a = 16;
      for (int k = 0; k < 24; k++) begin
        step(a < 20, AW'(a), 0, 0, 1, acc);
        if (acc) a++;
      end
    end

    // lone even, lone odd, pairs, broken pairs
    lst = '{6'd5, 6'd8, 6'd20, 6'd10, 6'd11, 6'd13, 6'd14, 6'd33, 6'd34, 6'd35};
    for (int i = 0; i < 10; i++) step(1, lst[i], 0, 0, 0, acc);
    for (int k = 0; k < 12; k++) step(0, 0, 0, 0, k % 3 != 0, acc);

    // hold: read hits a queued line, queue drains until it leaves
    lst = '{6'd30, 6'd31, 6'd40, 6'd41, 6'd50, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0};
    for (int i = 0; i < 5; i++) step(1, lst[i], 1, 6'd2, 1, acc);
    for (int k = 0; k < 6; k++) step(0, 0, 1, 6'd51, 1, acc);
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 1, acc);

    // pseudo-random sweep
    for (int k = 0; k < 4000; k++) begin
      lcg = nxt(lcg);
      step(lcg[31:30] != 0, lcg[21:16], lcg[29:27] == 0, lcg[15:10], lcg[26], acc);
    end
    for (int k = 0; k < 20; k++) step(0, 0, 0, 0, 1, acc);
    chk(!mem_req && !wr_full, "R3", {mem_req, wr_full}, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule